// File: doc/BRIEF.md
# Event Memory with Selectable Roll-Over

The block is a per-chip record store for a front-end readout chip. Each trigger pulse captures one record into a fixed-depth memory. A record holds the bunch-crossing counter value at the time of the trigger and a 2-bit hit code for each of the 64 channels. A readout port drains the stored records, oldest first, one record for each read request.

A configuration bit, set by slow control, picks how the memory behaves once it holds its capacity of records. With the bit low, the memory keeps the first records it captured and raises a saturation flag, so the acquisition controller can stop. With the bit high, the memory works as a ring: each new trigger overwrites the oldest record, so the most recent records are always held. A synchronous clear empties the store at the start of each acquisition. An occupancy output reports how many records are held.

Top module: `evt_store`

## Requirements
- R1: After reset, `count` is 0, `full` is 0 and `rd_valid` is 0.
- R2: A trigger (`trig`=1, `clear`=0) that is accepted stores the record {`bcid`, `hits`}. When no read is accepted in the same cycle, `count` is one higher in the following cycle.
- R3: With `roll_mode`=0 and `count` equal to DEPTH (127 by default), triggers are ignored. `count` does not change, and the records read out afterwards are the first DEPTH records captured.
- R4: `full` is 1 exactly when `roll_mode` is 0 and `count` equals DEPTH. In roll mode `full` stays 0.
- R5: With `roll_mode`=1 and `count` equal to DEPTH, a trigger overwrites the oldest record and `count` stays at DEPTH. The store then holds the last DEPTH records, and `count` never exceeds DEPTH.
- R6: When `rd_req`=1 and `count` is above 0, the cycle after the request shows `rd_valid`=1, with the oldest held record on `rd_bcid` and `rd_hits`. `count` drops by one.
- R7: A read request while `count` is 0 is ignored: `rd_valid` stays 0 and `count` stays 0.
- R8: `clear`=1 makes `count` 0, `full` 0 and `rd_valid` 0 in the next cycle. It overrides a trigger or read request in the same cycle, and only records captured after the clear are read out.
- R9: A trigger and a read in the same cycle both act. The read returns the oldest record held before that cycle, and `count` is unchanged. The one exception is a full store with `roll_mode`=0: there the trigger is ignored and `count` drops by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of the store at acquisition start |
| roll_mode | input | 1 | 0: keep the first DEPTH records; 1: keep the last DEPTH records |
| trig | input | 1 | Capture one record this cycle |
| bcid | input | 12 | Bunch-crossing counter value to store |
| hits | input | 128 | Channel hit codes, 2 bits per channel, channel 0 in bits 1:0 |
| rd_req | input | 1 | Request the oldest held record |
| rd_valid | output | 1 | Read data valid, one cycle after an accepted request |
| rd_bcid | output | 12 | Bunch-crossing value of the record read |
| rd_hits | output | 128 | Hit codes of the record read |
| full | output | 1 | Saturation flag in fill-once mode |
| count | output | 7 | Number of held records, at most DEPTH |

## Verification
The properties assume that `roll_mode` stays steady while the store holds records and changes only together with a clear. They also assume that all control inputs are synchronous to `clk` and have known values once reset is released. The stimulus respects both: it changes `roll_mode` only in the same cycle as a `clear` pulse, and it drives every input on the falling edge. Overflow, ring wrap and simultaneous trigger-and-read cases are reached by writing well past DEPTH in each mode and interleaving reads with those writes.

// File: rtl/evt_store_pkg.sv
`timescale 1ns/1ps
package evt_store_pkg;
    // Default geometry of one record and of the store
    localparam int unsigned BCID_BITS = 12;
    localparam int unsigned CHANNELS  = 64;
    localparam int unsigned HIT_BITS  = 2;
    localparam int unsigned SLOTS     = 127;

    // Next slot index of a ring of the given size
    function automatic int unsigned ring_next(int unsigned idx, int unsigned size);
        return (idx + 1 >= size) ? 0 : idx + 1;
    endfunction
endpackage

// File: rtl/evt_store_ctrl.sv
`timescale 1ns/1ps
module evt_store_ctrl
    import evt_store_pkg::*;
#(
    parameter int unsigned DEPTH = SLOTS,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             roll_mode,
    input  logic             trig,
    input  logic             rd_req,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_addr,
    output logic             rd_en,
    output logic [PTR_W-1:0] rd_addr,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             rd_valid
);
    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] count;
        logic             rd_valid;
    } ctrl_t;

    ctrl_t s_d, s_q;

    logic at_cap;
    logic rd_fire;
    logic wr_ok;
    logic drop_old;

    always_comb begin
        at_cap   = (s_q.count == CNT_W'(DEPTH));
        rd_fire  = rd_req && (s_q.count != '0) && !clear;
        wr_ok    = trig && !clear && (roll_mode || !at_cap);
        // ring full with no read: the oldest record gives way to the new one
        drop_old = wr_ok && at_cap && !rd_fire;

        s_d = s_q;
        s_d.rd_valid = rd_fire;
        if (wr_ok) begin
            s_d.wr_ptr = PTR_W'(ring_next(int'(s_q.wr_ptr), DEPTH));
        end
        if (rd_fire || drop_old) begin
            s_d.rd_ptr = PTR_W'(ring_next(int'(s_q.rd_ptr), DEPTH));
        end
        if (wr_ok && !rd_fire && !at_cap) begin
            s_d.count = s_q.count + CNT_W'(1);
        end else if (rd_fire && !wr_ok) begin
            s_d.count = s_q.count - CNT_W'(1);
        end
        if (clear) begin
            s_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_en    = wr_ok;
    assign wr_addr  = s_q.wr_ptr;
    assign rd_en    = rd_fire;
    assign rd_addr  = s_q.rd_ptr;
    assign count    = s_q.count;
    assign full     = !roll_mode && at_cap;
    assign rd_valid = s_q.rd_valid;
endmodule

// File: rtl/evt_store_mem.sv
`timescale 1ns/1ps
module evt_store_mem #(
    parameter int unsigned DEPTH = 127,
    parameter int unsigned WIDTH = 140,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic [PTR_W-1:0] rd_addr,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] slot_q [DEPTH];

    // Read returns the value held before a same-edge write to that slot
    always_ff @(posedge clk) begin
        if (wr_en) begin
            slot_q[wr_addr] <= wr_data;
        end
        if (rd_en) begin
            rd_data <= slot_q[rd_addr];
        end
    end
endmodule

// File: rtl/evt_store.sv
`timescale 1ns/1ps
module evt_store
    import evt_store_pkg::*;
#(
    parameter int unsigned DEPTH  = SLOTS,
    parameter int unsigned BCID_W = BCID_BITS,
    parameter int unsigned CH_N   = CHANNELS,
    parameter int unsigned HIT_W  = HIT_BITS,
    localparam int unsigned HITS_W = CH_N * HIT_W,
    localparam int unsigned REC_W  = BCID_W + HITS_W,
    localparam int unsigned PTR_W  = $clog2(DEPTH),
    localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              roll_mode,
    input  logic              trig,
    input  logic [BCID_W-1:0] bcid,
    input  logic [HITS_W-1:0] hits,
    input  logic              rd_req,
    output logic              rd_valid,
    output logic [BCID_W-1:0] rd_bcid,
    output logic [HITS_W-1:0] rd_hits,
    output logic              full,
    output logic [CNT_W-1:0]  count
);
    logic             wr_en;
    logic [PTR_W-1:0] wr_addr;
    logic             rd_en;
    logic [PTR_W-1:0] rd_addr;
    logic [REC_W-1:0] rd_rec;

    evt_store_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .roll_mode(roll_mode),
        .trig     (trig),
        .rd_req   (rd_req),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .count    (count),
        .full     (full),
        .rd_valid (rd_valid)
    );

    evt_store_mem #(.DEPTH(DEPTH), .WIDTH(REC_W)) u_mem (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data({bcid, hits}),
        .rd_en  (rd_en),
        .rd_addr(rd_addr),
        .rd_data(rd_rec)
    );

    assign rd_bcid = rd_rec[REC_W-1:HITS_W];
    assign rd_hits = rd_rec[HITS_W-1:0];
endmodule

// File: rtl/evt_store_chk.sv
`timescale 1ns/1ps
module evt_store_chk #(
    parameter int unsigned DEPTH = 127,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clear,
    input logic             roll_mode,
    input logic             trig,
    input logic             rd_req,
    input logic             rd_valid,
    input logic             full,
    input logic [CNT_W-1:0] count
);
    p_count_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        trig && !rd_req && !clear && (count < CNT_W'(DEPTH)) |=> count == $past(count) + CNT_W'(1));

    p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        full && trig && !rd_req && !clear && $stable(roll_mode) |=> full && $stable(count));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    p_roll_stay_r5: assert property (@(posedge clk) disable iff (!rst_n)
        roll_mode && (count == CNT_W'(DEPTH)) && trig && !rd_req && !clear |=> count == CNT_W'(DEPTH) && !full);

    p_read_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && (count != '0) && !clear |=> rd_valid);

    p_empty_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && (count == '0) |=> !rd_valid);

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0) && !rd_valid && !full);
endmodule

bind evt_store evt_store_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .roll_mode(roll_mode),
    .trig     (trig),
    .rd_req   (rd_req),
    .rd_valid (rd_valid),
    .full     (full),
    .count    (count)
);

// File: tb/sim_evt_store.sv
`timescale 1ns/1ps
module sim_evt_store;
    localparam int N = 127;

    typedef struct packed {
        logic [11:0]  b;
        logic [127:0] h;
    } rec_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clear = 1'b0;
    logic         roll_mode = 1'b0;
    logic         trig = 1'b0;
    logic [11:0]  bcid = '0;
    logic [127:0] hits = '0;
    logic         rd_req = 1'b0;
    logic         rd_valid;
    logic [11:0]  rd_bcid;
    logic [127:0] rd_hits;
    logic         full;
    logic [6:0]   count;

    int checks = 0;
    int fails  = 0;
    rec_t model_q[$];
    rec_t exp_q[$];
    int next_id = 0;

    always #2.5 clk = ~clk;

    evt_store u0 (
        .clk(clk), .rst_n(rst_n), .clear(clear), .roll_mode(roll_mode),
        .trig(trig), .bcid(bcid), .hits(hits), .rd_req(rd_req),
        .rd_valid(rd_valid), .rd_bcid(rd_bcid), .rd_hits(rd_hits),
        .full(full), .count(count)
    );

    function automatic rec_t make_rec(int k);
        rec_t r;
        r.b = 12'(k * 37 + 5);
        r.h = {4{32'(k) * 32'h9E3779B1}} ^ {32'(k), 96'h0};
        return r;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Driver: one cycle with optional trigger and read, model updated alongside
    task automatic cycle(bit do_trig, bit do_rd);
        rec_t r;
        bit accept;
        @(negedge clk);
        r = make_rec(next_id);
        accept = do_trig && (roll_mode || model_q.size() < N);
        if (do_rd && model_q.size() > 0) exp_q.push_back(model_q.pop_front());
        if (accept) begin
            model_q.push_back(r);
            if (model_q.size() > N) void'(model_q.pop_front());
        end
        trig   = do_trig;
        rd_req = do_rd;
        bcid   = r.b;
        hits   = r.h;
        if (do_trig) next_id++;
        @(negedge clk);
        trig   = 1'b0;
        rd_req = 1'b0;
    endtask

    task automatic do_clear(bit mode, bit with_trig);
        @(negedge clk);
        clear = 1'b1;
        roll_mode = mode;
        trig = with_trig;
        rd_req = with_trig;
        model_q.delete();
        @(negedge clk);
        clear = 1'b0;
        trig = 1'b0;
        rd_req = 1'b0;
    endtask

    task automatic drain(int n);
        for (int i = 0; i < n; i++) cycle(1'b0, 1'b1);
        @(negedge clk);
    endtask

    // Monitor: compares each returned record with the scoreboard head
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check("R7 unexpected rd_valid", 32'd1, 32'd0);
            end else begin
                rec_t e;
                e = exp_q.pop_front();
                check("R6 rd_bcid", 32'(rd_bcid), 32'(e.b));
                check("R6 rd_hits", 32'(rd_hits ^ (rd_hits >> 64) ^ (rd_hits >> 96)),
                      32'(e.h ^ (e.h >> 64) ^ (e.h >> 96)));
            end
        end
    end

    task automatic finish_run();
        check("R6 pending reads", 32'(exp_q.size()), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 count", 32'(count), 32'd0);
        check("R1 full", 32'(full), 32'd0);
        check("R1 rd_valid", 32'(rd_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R6: small fill-once acquisition
        for (int i = 0; i < 5; i++) cycle(1'b1, 1'b0);
        check("R2 count after 5", 32'(count), 32'd5);
        drain(2);
        check("R6 count after 2 reads", 32'(count), 32'd3);
        // R9: trigger and read together
        cycle(1'b1, 1'b1);
        check("R9 count unchanged", 32'(count), 32'd3);
        @(negedge clk);

        // R8: clear wins over trigger and read in the same cycle
        do_clear(1'b0, 1'b1);
        check("R8 count after clear", 32'(count), 32'd0);
        check("R8 rd_valid after clear", 32'(rd_valid), 32'd0);
        exp_q.delete();

        // R3 / R4: overfill in fill-once mode
        for (int i = 0; i < N + 3; i++) cycle(1'b1, 1'b0);
        check("R3 count capped", 32'(count), 32'(N));
        check("R4 full set", 32'(full), 32'd1);
        cycle(1'b1, 1'b0);
        check("R3 ignored trigger", 32'(count), 32'(N));
        // R9 exception: full, fill-once, trigger plus read
        cycle(1'b1, 1'b1);
        check("R9 full fill-once drop", 32'(count), 32'(N - 1));
        check("R4 full cleared", 32'(full), 32'd0);
        drain(N - 1);
        check("R3 drained", 32'(count), 32'd0);
        // R7: read on empty
        cycle(1'b0, 1'b1);
        check("R7 rd_valid on empty", 32'(rd_valid), 32'd0);
        check("R7 count on empty", 32'(count), 32'd0);

        // R5: roll mode keeps the last records
        do_clear(1'b1, 1'b0);
        for (int i = 0; i < N + 73; i++) cycle(1'b1, 1'b0);
        check("R5 count capped", 32'(count), 32'(N));
        check("R4 full low in roll", 32'(full), 32'd0);
        drain(3);
        check("R5 count after reads", 32'(count), 32'(N - 3));
        for (int i = 0; i < 10; i++) cycle(1'b1, 1'b0);
        check("R5 count refilled", 32'(count), 32'(N));
        cycle(1'b1, 1'b1);
        check("R9 roll full trig+read", 32'(count), 32'(N));
        drain(N);
        check("R5 drained", 32'(count), 32'd0);

        // R8: only records after a clear come out
        for (int i = 0; i < 4; i++) cycle(1'b1, 1'b0);
        do_clear(1'b0, 1'b0);
        for (int i = 0; i < 2; i++) cycle(1'b1, 1'b0);
        check("R8 count post clear", 32'(count), 32'd2);
        drain(2);
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule